// File: doc/BRIEF.md
# Windowed Paging Address Translator

This block sits between a processor with a 15-bit word address space and a memory of 2^18 words. Two fixed 256-word windows at the top of the processor space can be redirected to any 256-word frame of physical memory. The main window covers octal 77400 to 77777 and a buffer window covers octal 77000 to 77377. Any address outside a window, and any window whose entry is inactive, reaches physical memory at the same numeric address with the three upper bits zero.

Software sets up the translator through a small register write port. One register is a table pointer. The translator is enabled only while this pointer is non-zero. Each window also has an entry register that holds a 10-bit frame number and three flags: active, security and read-only. Translation is combinational in the same cycle as the access. A write to a read-only mapped window is blocked at the memory write enable and reported by a fault output in that cycle.

Top module: `pager_top`

## Requirements
- R1: After reset the pointer and both entries are zero, so every access passes through: physAddr = {3'b000, cpuAddr}, and memWe = cpuValid & cpuWrite.
- R2: physAddr[7:0] always equals cpuAddr[7:0].
- R3: An address whose bits 14..8 are neither 7'h7F nor 7'h7E passes through untranslated, whatever the register contents.
- R4: Window 0 is the page cpuAddr[14:8] = 7'h7F (octal 77400..77777) and window 1 is the page 7'h7E (octal 77000..77377). regSel = 0 loads the pointer, regSel = 1 loads the window 0 entry and regSel = 2 loads the window 1 entry.
- R5: An entry uses regData[17:8] as the frame, bit 7 as read-only, bit 6 as security and bit 5 as active. Bits 4..0 are ignored. While the pager is enabled, an access in a window with an active entry gives physAddr = {frame, cpuAddr[7:0]}.
- R6: An access in a window whose entry has the active bit clear goes to the real untranslated location.
- R7: The pager is enabled only while the pointer register is non-zero. A zero pointer disables every translation.
- R8: A register write takes effect on the clock edge that ends its cycle. An access in the same cycle still uses the old value.
- R9: A write (cpuValid & cpuWrite) to a translated window with the read-only bit set drives memWe low and fault high in that cycle. Reads of such a window translate normally. fault is never high without a valid write.
- R10: pageSecure is high exactly when the access is translated through an entry whose security bit is set.
- R11: A register write with regSel = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 15 | Processor word address |
| cpuValid | input | 1 | Access in progress this cycle |
| cpuWrite | input | 1 | Access is a store |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 pointer, 1 window 0 entry, 2 window 1 entry |
| regData | input | 18 | Register write data |
| physAddr | output | 18 | Physical memory address |
| memWe | output | 1 | Memory write enable after protection |
| fault | output | 1 | Blocked write to a read-only page |
| pageSecure | output | 1 | Access was translated through a security-flagged entry |

## Verification
The hardest case to reach is a store into a translated read-only window. It needs a non-zero pointer, an active entry with the read-only bit set, and an address in that same window, all at once. Random register writes set the flag bits with even odds and make the pointer non-zero two times out of three. Access addresses are drawn mostly from the two window pages and the page just below them. A directed sequence also loads a read-only entry and stores into it. It then writes an entry and uses it in the same cycle to show the one-cycle load latency.

// File: rtl/pager_pkg.sv
package pager_pkg;
  localparam int unsigned VA_W    = 15;
  localparam int unsigned PA_W    = 18;
  localparam int unsigned OFF_W   = 8;
  localparam int unsigned FRAME_W = PA_W - OFF_W;
  localparam int unsigned PAGE_W  = VA_W - OFF_W;
  localparam int unsigned N_WIN   = 2;
  localparam int unsigned SEL_W   = $clog2(N_WIN + 1);
  // flag positions inside an entry word; fixed by the entry format
  localparam int unsigned RO_BIT  = 7;
  localparam int unsigned SEC_BIT = 6;
  localparam int unsigned ACT_BIT = 5;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               ro;
    logic               sec;
    logic               act;
  } pte_t;

  typedef struct packed {
    logic             ptrLoad;
    logic [N_WIN-1:0] entLoad;
    logic             mapEn;
  } strobes_t;
endpackage

// File: rtl/pager_datapath.sv
module pager_datapath
  import pager_pkg::*;
#(
  parameter int unsigned PTR_W = 18
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic [PA_W-1:0] regData,
  input  logic [VA_W-1:0] cpuAddr,
  output logic [PA_W-1:0] physAddr,
  output logic            hitAct,
  output logic            hitRo,
  output logic            hitSec,
  output logic            ptrNonZero
);
  localparam logic [PAGE_W-1:0] TOP_PAGE = {PAGE_W{1'b1}};

  logic [PTR_W-1:0] ptrQ;
  pte_t             entQ [N_WIN];
  logic [N_WIN-1:0] winHit;
  pte_t             selEnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptrQ <= '0;
    else if (stb.ptrLoad) ptrQ <= PTR_W'(regData);
  end
  assign ptrNonZero = |ptrQ;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entQ[w] <= '0;
      else if (stb.entLoad[w]) begin
        entQ[w].frame <= regData[PA_W-1:OFF_W];
        entQ[w].ro    <= regData[RO_BIT];
        entQ[w].sec   <= regData[SEC_BIT];
        entQ[w].act   <= regData[ACT_BIT];
      end
    end
    assign winHit[w] = (cpuAddr[VA_W-1:OFF_W] == TOP_PAGE - PAGE_W'(w));

    p_entry_load_r8: assert property (@(posedge clk) disable iff (!rstN)
      stb.entLoad[w] |=> (entQ[w].frame == $past(regData[PA_W-1:OFF_W]))
                         && (entQ[w].act == $past(regData[ACT_BIT])));
  end

  always_comb begin
    selEnt = '0;
    for (int w = 0; w < N_WIN; w++)
      if (winHit[w]) selEnt = entQ[w];
  end

  assign hitAct = selEnt.act;
  assign hitRo  = selEnt.ro;
  assign hitSec = selEnt.sec;

  assign physAddr = stb.mapEn ? {selEnt.frame, cpuAddr[OFF_W-1:0]}
                              : PA_W'(cpuAddr);

  p_window_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winHit));
  p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrLoad |=> (ptrNonZero == ($past(regData[PTR_W-1:0]) != '0)));
endmodule

// File: rtl/pager_ctrl.sv
module pager_ctrl
  import pager_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regSel,
  input  logic             cpuValid,
  input  logic             cpuWrite,
  input  logic             hitAct,
  input  logic             hitRo,
  input  logic             hitSec,
  input  logic             ptrNonZero,
  output strobes_t         stb,
  output logic             memWe,
  output logic             fault,
  output logic             pageSecure
);
  logic isStore;

  always_comb begin
    stb.ptrLoad = regWe && (regSel == '0);
    for (int w = 0; w < N_WIN; w++)
      stb.entLoad[w] = regWe && (regSel == SEL_W'(w + 1));
    stb.mapEn = ptrNonZero && hitAct;
  end

  assign isStore    = cpuValid && cpuWrite;
  assign fault      = isStore && stb.mapEn && hitRo;
  assign memWe      = isStore && !fault;
  assign pageSecure = stb.mapEn && hitSec;

  p_fault_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (cpuValid && cpuWrite && !memWe));
  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ptrLoad, stb.entLoad}));
  p_bad_sel_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regSel > SEL_W'(N_WIN)) |-> ({stb.ptrLoad, stb.entLoad} == '0));
  p_secure_mapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    pageSecure |-> ptrNonZero);
endmodule

// File: rtl/pager_top.sv
module pager_top
  import pager_pkg::*;
#(
  parameter int unsigned PTR_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VA_W-1:0]  cpuAddr,
  input  logic             cpuValid,
  input  logic             cpuWrite,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regSel,
  input  logic [PA_W-1:0]  regData,
  output logic [PA_W-1:0]  physAddr,
  output logic             memWe,
  output logic             fault,
  output logic             pageSecure
);
  strobes_t stb;
  logic hitAct, hitRo, hitSec, ptrNonZero;

  pager_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .hitAct(hitAct),
    .hitRo(hitRo), .hitSec(hitSec), .ptrNonZero(ptrNonZero),
    .stb(stb), .memWe(memWe), .fault(fault), .pageSecure(pageSecure)
  );

  pager_datapath #(.PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regData(regData),
    .cpuAddr(cpuAddr), .physAddr(physAddr), .hitAct(hitAct),
    .hitRo(hitRo), .hitSec(hitSec), .ptrNonZero(ptrNonZero)
  );

  localparam logic [PAGE_W-1:0] LOW_WIN_PAGE = {PAGE_W{1'b1}} - PAGE_W'(N_WIN - 1);

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[OFF_W-1:0] == cpuAddr[OFF_W-1:0]);
  p_outside_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[VA_W-1:OFF_W] < LOW_WIN_PAGE) |-> (physAddr == PA_W'(cpuAddr)));
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (physAddr[PA_W-1:VA_W] != '0) |-> (cpuAddr[VA_W-1:OFF_W] >= LOW_WIN_PAGE));
endmodule

// File: tb/tb_pager_top.sv
module tb_pager_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] cpuAddr = '0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0, regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [17:0] regData = '0;
  logic [17:0] physAddr;
  logic        memWe, fault, pageSecure;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // model state
  logic [17:0] mPtr;
  logic [17:0] mEnt [2];

  always #10 clk = ~clk;  // 50 MHz

  pager_top dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuValid(cpuValid),
    .cpuWrite(cpuWrite), .regWe(regWe), .regSel(regSel), .regData(regData),
    .physAddr(physAddr), .memWe(memWe), .fault(fault), .pageSecure(pageSecure)
  );

  task automatic check(string tag, logic [20:0] got, logic [20:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h (physAddr,memWe,fault,secure)", tag, got, exp);
    end
  endtask

  // expected outputs from the requirements, plus the requirement tag
  function automatic logic [20:0] expect_out(input logic [14:0] a, input logic v,
                                             input logic wr, output string tag);
    logic [17:0] e;
    int win;
    logic mapped;
    win = (a[14:8] == 7'h7F) ? 0 : (a[14:8] == 7'h7E) ? 1 : -1;
    mapped = 1'b0;
    e = '0;
    if (win < 0) tag = "R3";
    else begin
      e = mEnt[win];
      if (mPtr == '0) tag = "R7";
      else if (!e[5]) tag = "R6";
      else begin
        mapped = 1'b1;
        tag = (e[7] && v && wr) ? "R9" : e[6] ? "R10" : "R5";
      end
    end
    if (mapped)
      return {e[17:8], a[7:0], v && wr && !e[7], v && wr && e[7], e[6]};
    return {3'b000, a, v && wr, 1'b0, 1'b0};
  endfunction

  task automatic step(input logic [14:0] a, input logic v, input logic wr,
                      input logic we, input logic [1:0] sel, input logic [17:0] d,
                      input string extra);
    string tag;
    logic [20:0] exp;
    cpuAddr = a; cpuValid = v; cpuWrite = wr;
    regWe = we; regSel = sel; regData = d;
    #8;
    exp = expect_out(a, v, wr, tag);
    if (extra != "") tag = extra;
    check(tag, {physAddr, memWe, fault, pageSecure}, exp);
    nChecks++;
    if (physAddr[7:0] !== a[7:0]) begin
      nFails++;
      $display("FAIL R2: offset %h expected %h", physAddr[7:0], a[7:0]);
    end
    @(posedge clk);
    #1;
    if (we) begin
      if (sel == 2'd0) mPtr = d;
      else if (sel == 2'd1) mEnt[0] = d;
      else if (sel == 2'd2) mEnt[1] = d;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [14:0] a;
    logic [17:0] d;
    void'($urandom(32'd4242));
    mPtr = '0; mEnt[0] = '0; mEnt[1] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, window addresses pass through
    step(15'o77400, 1, 1, 0, 0, 0, "R1");
    step(15'o77123, 1, 0, 0, 0, 0, "R1");
    // R6: active entry written, pointer zero -> still real 77400 (R7)
    step(15'o00000, 0, 0, 1, 2'd1, 18'o077040, "R3");
    step(15'o77400, 1, 1, 0, 0, 0, "R7");
    // R8: pointer written this cycle, access still untranslated
    step(15'o77400, 1, 1, 1, 2'd0, 18'o000701, "R8");
    // R5: store through 77400 lands at physical 77000
    step(15'o77400, 1, 1, 0, 0, 0, "R5");
    // R4: window boundaries
    step(15'o77377, 1, 0, 0, 0, 0, "R4");
    step(15'o77777, 1, 0, 0, 0, 0, "R4");
    // R8: entry loaded this cycle, used next
    step(15'o77000, 1, 0, 1, 2'd2, 18'o512377, "R8");
    step(15'o77055, 1, 0, 0, 0, 0, "R5");
    // R11: select 3 changes nothing
    step(15'o77000, 1, 0, 1, 2'd3, 18'o000000, "R11");
    step(15'o77000, 1, 0, 0, 0, 0, "R11");
    step(15'o77400, 1, 1, 0, 0, 0, "R11");
    // R9: read-only entry, store blocked; read allowed; R10 secure
    step(15'o77400, 1, 0, 1, 2'd1, 18'o123340, "R9");
    step(15'o77401, 1, 1, 0, 0, 0, "R9");
    step(15'o77402, 1, 0, 0, 0, 0, "R9");
    step(15'o77403, 0, 1, 0, 0, 0, "R9");
    step(15'o77404, 1, 0, 1, 2'd1, 18'o333140, "R10");
    step(15'o77405, 1, 1, 0, 0, 0, "R10");
    // R6: inactive entry with frame set
    step(15'o77406, 1, 1, 1, 2'd1, 18'o777700, "R6");
    step(15'o77407, 1, 1, 0, 0, 0, "R6");
    // R7: clearing the pointer disables window 1
    step(15'o77001, 1, 0, 1, 2'd0, 18'o0, "R7");
    step(15'o77001, 1, 1, 0, 0, 0, "R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 4)
        0: a = 15'($urandom);
        1: a = {7'h7F, 8'($urandom)};
        2: a = {7'h7E, 8'($urandom)};
        default: a = {7'h7D, 8'($urandom)};
      endcase
      d = 18'($urandom);
      if (($urandom % 3) == 0) d = '0;
      step(a, 1'($urandom), 1'($urandom), ($urandom % 8) == 0, 2'($urandom), d, "");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule